// File: doc/BRIEF.md
# Sleep Mode and Wake-up Controller

This block sits in the always-on part of a small microcontroller and decides when the core's main clock may run. When the core raises a sleep request, a two-bit mode field selects one of three outcomes. Two values give a light sleep that keeps the clock running. One value gives a deep power-down state, and one gives a power-save state. In the two deep states the clock-enable output is dropped, and the block waits for one of a fixed set of wake sources.

There are two kinds of wake source. Reset-type sources are the external, watchdog and brown-out reset requests. Interrupt-type sources are a serial-bus address match, a level-sensitive external interrupt and, in power-save only, events from an asynchronously clocked timer. The external level is filtered on a slow always-on tick: it only counts after two consecutive samples at the active level.

Once a deep-sleep wake is accepted, a start-up delay counted in slow ticks runs before the clock comes back. The length of this delay is a configuration input that is shared with the reset time-out setting. On the first running cycle, the block pulses either a reset request or a wake interrupt, depending on which kind of source woke it.

Top module: `slumber_ctl`

## Requirements
- R1: After reset, `core_clk_en` is 1, and `starting`, `reset_req`, `wake_irq` and `tmr_undef` are 0.
- R2: A sleep request with `sleep_mode` = 2'b10 enters power-down and one with 2'b11 enters power-save; in both, `core_clk_en` reads 0 from the cycle after the request.
- R3: A sleep request with `sleep_mode` = 2'b00 or 2'b01 keeps `core_clk_en` at 1. Any raw wake source, including an unfiltered external level, ends this light sleep. The matching pulse appears in the next cycle, with no delay.
- R4: In power-down, only these sources wake the core: a reset source, the address match, or the filtered external level. Timer events are ignored there.
- R5: The external level counts only once two consecutive `slow_tick` samples have seen it high. A level that is high on a single sample does not wake the core.
- R6: After a deep wake is accepted, `starting` is 1 for exactly `startup_cnt`+1 `slow_tick` pulses. `core_clk_en` returns to 1 in the cycle after the last of them.
- R7: In power-save, a timer overflow or compare event wakes the core only when all three hold: `tmr_async` is 1, that event's enable is 1, and `gie` is 1.
- R8: A wake caused by a reset source gives a one-cycle `reset_req` pulse on the first cycle with `core_clk_en` back at 1. If a reset source and an interrupt source are both present, the reset source wins.
- R9: A wake caused only by interrupt-type sources gives a one-cycle `wake_irq` pulse instead, at the same point. `reset_req` and `wake_irq` are never both 1.
- R10: `tmr_undef` is rewritten at every sleep entry. It reads 1 only when power-save was entered with `tmr_async` at 0.
- R11: A sleep request is ignored while a qualified wake source is present in the same cycle. The qualified sources are a reset source, the address match, the filtered level, or a fully enabled timer event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset |
| sleep_req | input | 1 | One-cycle sleep request from the core |
| sleep_mode | input | 2 | Mode field qualifying the request |
| slow_tick | input | 1 | One-cycle strobe from the slow always-on oscillator |
| ext_rst_wake | input | 1 | External reset source |
| wdt_rst_wake | input | 1 | Watchdog reset source |
| bod_rst_wake | input | 1 | Brown-out reset source |
| addr_match_irq | input | 1 | Serial-bus address-match interrupt |
| ext_level_irq | input | 1 | Active-high level external interrupt |
| tmr_async | input | 1 | Timer runs from its own asynchronous clock |
| tmr_ovf_evt | input | 1 | Timer overflow event |
| tmr_cmp_evt | input | 1 | Timer compare event |
| tmr_ovf_ie | input | 1 | Overflow interrupt enable |
| tmr_cmp_ie | input | 1 | Compare interrupt enable |
| gie | input | 1 | Global interrupt enable |
| startup_cnt | input | CNT_W | Start-up delay setting, shared with reset time-out |
| core_clk_en | output | 1 | Core clock enable |
| starting | output | 1 | Start-up delay in progress |
| reset_req | output | 1 | One-cycle reset request after a reset-type wake |
| wake_irq | output | 1 | One-cycle wake interrupt after an interrupt-type wake |
| tmr_undef | output | 1 | Timer contents undefined after this sleep |

## Verification
Every start-up setting is combined with every single power-down wake source. This sweep tells a delay that is off by one tick apart from a correct one, and a reset-type cause apart from an interrupt-type one. In power-save, the timer is swept over all combinations of asynchronous mode, its local enable and the global enable, for both overflow and compare events. Exactly one of these combinations per event may wake the core, and the sweep checks that. Separate patterns compare a level held for one slow sample against one held for two, check light sleep against deep sleep, and check a sleep request made while a wake source is already pending.

// File: rtl/slumber_ctl.sv
module slumber_ctl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic [1:0]       sleep_mode,
  input  logic             slow_tick,
  input  logic             ext_rst_wake,
  input  logic             wdt_rst_wake,
  input  logic             bod_rst_wake,
  input  logic             addr_match_irq,
  input  logic             ext_level_irq,
  input  logic             tmr_async,
  input  logic             tmr_ovf_evt,
  input  logic             tmr_cmp_evt,
  input  logic             tmr_ovf_ie,
  input  logic             tmr_cmp_ie,
  input  logic             gie,
  input  logic [CNT_W-1:0] startup_cnt,
  output logic             core_clk_en,
  output logic             starting,
  output logic             reset_req,
  output logic             wake_irq,
  output logic             tmr_undef
);

  typedef enum logic [2:0] {S_RUN, S_IDLE, S_DOWN, S_SAVE, S_START} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             cause_rst;
  logic             lvl_s1, lvl_s2;

  logic rst_src, tmr_hit, lvl_ok, pend, deep_wake, idle_wake;

  assign rst_src   = ext_rst_wake | wdt_rst_wake | bod_rst_wake;
  assign tmr_hit   = tmr_async & gie &
                     ((tmr_ovf_evt & tmr_ovf_ie) | (tmr_cmp_evt & tmr_cmp_ie));
  assign lvl_ok    = lvl_s1 & lvl_s2;
  assign pend      = rst_src | addr_match_irq | lvl_ok | tmr_hit;
  assign deep_wake = rst_src | addr_match_irq | lvl_ok | ((st == S_SAVE) & tmr_hit);
  assign idle_wake = rst_src | addr_match_irq | ext_level_irq | tmr_hit;

  assign core_clk_en = (st == S_RUN) | (st == S_IDLE);
  assign starting    = (st == S_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      cnt       <= '0;
      cause_rst <= 1'b0;
      lvl_s1    <= 1'b0;
      lvl_s2    <= 1'b0;
      reset_req <= 1'b0;
      wake_irq  <= 1'b0;
      tmr_undef <= 1'b0;
    end else begin
      reset_req <= 1'b0;
      wake_irq  <= 1'b0;
      if (slow_tick) begin
        lvl_s1 <= ext_level_irq;
        lvl_s2 <= lvl_s1;
      end
      case (st)
        S_RUN: begin
          if (sleep_req && !pend) begin
            tmr_undef <= (sleep_mode == 2'b11) & ~tmr_async;
            if (!sleep_mode[1])     st <= S_IDLE;
            else if (sleep_mode[0]) st <= S_SAVE;
            else                    st <= S_DOWN;
          end
        end
        S_IDLE: begin
          if (idle_wake) begin
            st        <= S_RUN;
            reset_req <= rst_src;
            wake_irq  <= ~rst_src;
          end
        end
        S_DOWN, S_SAVE: begin
          if (deep_wake) begin
            st        <= S_START;
            cnt       <= startup_cnt;
            cause_rst <= rst_src;
          end
        end
        S_START: begin
          if (slow_tick) begin
            if (cnt == '0) begin
              st        <= S_RUN;
              reset_req <= cause_rst;
              wake_irq  <= ~cause_rst;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        default: st <= S_RUN;
      endcase
    end
  end

  // R2
  deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && !starting && sleep_req && sleep_mode[1] && !pend && st == S_RUN)
      |=> !core_clk_en);

  // R11
  pend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && sleep_req && pend) |=> (st == S_RUN));

  // R6
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (starting && !slow_tick) |=> starting);

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reset_req && wake_irq));

  // R8
  pulse_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req || wake_irq) |-> core_clk_en);

  // R4
  down_tmr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DOWN && !rst_src && !addr_match_irq && !lvl_ok) |=> (st == S_DOWN));

endmodule

// File: tb/slumber_ctl_tb.sv
module slumber_ctl_tb;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 0, slow_tick = 0;
  logic [1:0] sleep_mode = 2'b00;
  logic ext_rst_wake = 0, wdt_rst_wake = 0, bod_rst_wake = 0;
  logic addr_match_irq = 0, ext_level_irq = 0;
  logic tmr_async = 0, tmr_ovf_evt = 0, tmr_cmp_evt = 0;
  logic tmr_ovf_ie = 0, tmr_cmp_ie = 0, gie = 0;
  logic [CW-1:0] startup_cnt = '0;
  logic core_clk_en, starting, reset_req, wake_irq, tmr_undef;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slumber_ctl #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
    .slow_tick(slow_tick), .ext_rst_wake(ext_rst_wake), .wdt_rst_wake(wdt_rst_wake),
    .bod_rst_wake(bod_rst_wake), .addr_match_irq(addr_match_irq),
    .ext_level_irq(ext_level_irq), .tmr_async(tmr_async), .tmr_ovf_evt(tmr_ovf_evt),
    .tmr_cmp_evt(tmr_cmp_evt), .tmr_ovf_ie(tmr_ovf_ie), .tmr_cmp_ie(tmr_cmp_ie),
    .gie(gie), .startup_cnt(startup_cnt), .core_clk_en(core_clk_en),
    .starting(starting), .reset_req(reset_req), .wake_irq(wake_irq),
    .tmr_undef(tmr_undef)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tk();
    slow_tick = 1'b1;
    cyc();
    slow_tick = 1'b0;
  endtask

  task automatic enter(input logic [1:0] m);
    sleep_mode = m;
    sleep_req = 1'b1;
    cyc();
    sleep_req = 1'b0;
  endtask

  task automatic finish_delay(input int sel, input bit exp_rst, input string tag);
    int n = 0;
    while (1) begin
      tk();
      n++;
      if (core_clk_en || n > 40) break;
      cyc();
    end
    chk(n == sel + 1, {"R6 delay ", tag}, n, sel + 1);
    chk(reset_req == exp_rst, {"R8 reset_req ", tag}, int'(reset_req), int'(exp_rst));
    chk(wake_irq == !exp_rst, {"R9 wake_irq ", tag}, int'(wake_irq), int'(!exp_rst));
    cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1
    chk(core_clk_en && !starting && !reset_req && !wake_irq && !tmr_undef,
        "R1 reset state", int'(core_clk_en), 1);

    // R2 R4 R5 R6 R8 R9: every delay setting with every power-down source
    for (int sel = 0; sel < (1 << CW); sel++) begin
      for (int src = 0; src < 5; src++) begin
        startup_cnt = sel[CW-1:0];
        enter(2'b10);
        chk(!core_clk_en, "R2 power-down clock off", int'(core_clk_en), 0);
        chk(!tmr_undef, "R10 undef after power-down", int'(tmr_undef), 0);
        if (src == 4) begin
          ext_level_irq = 1'b1;
          tk(); cyc(); tk(); cyc();
          ext_level_irq = 1'b0;
        end else begin
          case (src)
            0: ext_rst_wake = 1'b1;
            1: wdt_rst_wake = 1'b1;
            2: bod_rst_wake = 1'b1;
            default: addr_match_irq = 1'b1;
          endcase
          cyc();
          ext_rst_wake = 0; wdt_rst_wake = 0; bod_rst_wake = 0; addr_match_irq = 0;
        end
        chk(starting, "R4 power-down wake accepted", int'(starting), 1);
        finish_delay(sel, src < 3, $sformatf("sel=%0d src=%0d", sel, src));
      end
    end

    // R4: timer events ignored in power-down even when fully enabled
    startup_cnt = '0;
    tmr_async = 1; gie = 1; tmr_ovf_ie = 1; tmr_cmp_ie = 1;
    enter(2'b10);
    tmr_ovf_evt = 1; tmr_cmp_evt = 1; cyc(); tmr_ovf_evt = 0; tmr_cmp_evt = 0;
    cyc();
    chk(!core_clk_en && !starting, "R4 timer ignored in power-down", int'(starting), 0);
    addr_match_irq = 1; cyc(); addr_match_irq = 0;
    finish_delay(0, 0, "R4 exit");

    // R5: level high on one sample only does not wake
    enter(2'b10);
    ext_level_irq = 1; tk(); cyc(); ext_level_irq = 0; tk(); cyc(); tk(); cyc();
    chk(!core_clk_en && !starting, "R5 single-sample level ignored", int'(starting), 0);
    addr_match_irq = 1; cyc(); addr_match_irq = 0;
    finish_delay(0, 0, "R5 exit");

    // R7 R10: power-save timer sweep
    for (int ev = 0; ev < 2; ev++) begin
      for (int c = 0; c < 8; c++) begin
        bit exp_wake;
        tmr_async = c[0]; tmr_ovf_ie = c[1]; tmr_cmp_ie = c[1]; gie = c[2];
        exp_wake = c[0] & c[1] & c[2];
        enter(2'b11);
        chk(!core_clk_en, "R2 power-save clock off", int'(core_clk_en), 0);
        chk(tmr_undef == !c[0], "R10 undef flag", int'(tmr_undef), int'(!c[0]));
        if (ev == 0) tmr_ovf_evt = 1; else tmr_cmp_evt = 1;
        cyc();
        tmr_ovf_evt = 0; tmr_cmp_evt = 0;
        chk(starting == exp_wake, $sformatf("R7 timer wake ev=%0d c=%0d", ev, c),
            int'(starting), int'(exp_wake));
        if (!exp_wake) begin
          addr_match_irq = 1; cyc(); addr_match_irq = 0;
        end
        finish_delay(0, 0, "R7 exit");
      end
    end
    tmr_async = 0; gie = 0; tmr_ovf_ie = 0; tmr_cmp_ie = 0;

    // R8: reset beats interrupt when both present
    enter(2'b10);
    bod_rst_wake = 1; addr_match_irq = 1; cyc(); bod_rst_wake = 0; addr_match_irq = 0;
    finish_delay(0, 1, "R8 precedence");

    // R3: light sleep modes
    for (int m = 0; m < 2; m++) begin
      enter(m[1:0]);
      chk(core_clk_en, "R3 light sleep clock on", int'(core_clk_en), 1);
      ext_level_irq = 1; cyc(); ext_level_irq = 0;
      chk(wake_irq && !reset_req, "R3 raw level wakes light sleep", int'(wake_irq), 1);
      enter(m[1:0]);
      wdt_rst_wake = 1; cyc(); wdt_rst_wake = 0;
      chk(reset_req && !wake_irq, "R3 reset wakes light sleep", int'(reset_req), 1);
      cyc();
    end
    tk(); cyc(); tk(); cyc();

    // R11: sleep request ignored with a pending source
    addr_match_irq = 1;
    enter(2'b10);
    addr_match_irq = 0;
    chk(core_clk_en && !starting, "R11 request ignored", int'(core_clk_en), 1);
    cyc();
    chk(core_clk_en, "R11 still running", int'(core_clk_en), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule